// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Data Cache

This block is the lookup stage of a 16 KB, 4-way set-associative level-one data cache for a machine with 32-bit addresses and 4 KB pages. Lines are 32 bytes, so there are 128 sets. The line offset and the set index both lie inside the 12-bit page offset. A request therefore carries only those untranslated bits, and the set is selected at once. The physical page number comes back from the translation unit one or more cycles later. It is then compared against the four stored tags of the chosen set.

A read hit returns the addressed 32-bit word in the same cycle that the page number arrives. A read miss sends one line-aligned fill request to the next level. The line then returns as eight 32-bit beats in ascending word order, and the pending read is answered from the newly installed line. A store is always forwarded to the next level as a word write. If the line is present, the store also updates it. A store never allocates a line. A global invalidate sweeps the valid bits one set per cycle, and new requests are held off while it runs.

Top module: `vipt_cache`

## Requirements
- R1: After reset every line is invalid, `reqReady` is 1 and `rspValid` and `memReqValid` are 0, so the first read of any address misses.
- R2: A request is taken in a cycle with `reqValid` and `reqReady` both high. `reqOffs[11:5]` selects the set and `reqOffs[4:2]` selects the word. `reqReady` is 0 in the following cycle.
- R3: After a request is taken, `rspValid` and `memReqValid` stay 0 until the cycle in which `ppnValid` is high, however many cycles that takes.
- R4: A read whose page number matches a valid tag in the set raises `rspValid` in the `ppnValid` cycle, with `rspData` equal to the addressed word. It raises no `memReqValid`.
- R5: A read miss raises `memReqValid` for the `ppnValid` cycle only, with `memReqWrite`=0, `memReqAddr`={ppn, set, 5'b0} and `rspValid`=0.
- R6: After a read miss, the line is taken as eight `fillValid` beats, word 0 first. `rspValid` rises in the cycle after the eighth beat, with the requested word. The line is valid for later reads only from then on.
- R7: A miss fills the lowest-numbered invalid way if there is one. Otherwise it fills the way named by a 3-bit tree per set, where bit0 chooses the pair (0: ways 0/1, 1: ways 2/3), bit1 chooses within ways 0/1 and bit2 chooses within ways 2/3. Every hit and every fill points the tree away from the way used.
- R8: A store raises `memReqValid` with `memReqWrite`=1, `memReqAddr`={ppn, set, word, 2'b00} and `memReqWdata` equal to the store data, and raises `rspValid` in the same `ppnValid` cycle. If the line is present, the word in it is updated.
- R9: A store that misses leaves the cache unchanged, so a later read of the same address misses.
- R10: `invAll` seen in an idle cycle makes `reqReady` 0 in that cycle and for the next 128 cycles. Afterwards every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| invAll | input | 1 | Start a global invalidate (honoured when idle, priority over a request) |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can take a request this cycle |
| reqWrite | input | 1 | 1 = store, 0 = read |
| reqOffs | input | 12 | Untranslated page-offset bits of the address |
| reqWdata | input | 32 | Store data |
| ppnValid | input | 1 | Translation result present |
| ppn | input | 20 | Physical page number from translation |
| rspValid | output | 1 | Read data valid, or store done |
| rspData | output | 32 | Read word |
| memReqValid | output | 1 | Next-level request (one cycle) |
| memReqWrite | output | 1 | 1 = word write, 0 = line fill |
| memReqAddr | output | 32 | Next-level physical address |
| memReqWdata | output | 32 | Word write data |
| fillValid | input | 1 | Fill beat present |
| fillData | input | 32 | Fill beat data |

## Verification
A wrong tag or valid bit shows up in the very cycle of the next access to that set. Either a fill request appears where data was expected, or data appears where a fill request was expected. A fault in the replacement tree stays hidden until a set is full. It appears only later, when a line that should have survived misses, so the bench fills one set completely and then checks exactly which lines remain. An error in the invalidate sweep shows up as a stall that is one cycle too short or too long, or as a stale hit once the sweep has ended.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef struct packed {
    logic latchReq;
    logic touch;
    logic storeWord;
    logic startFill;
    logic writeBeat;
    logic finishFill;
    logic useHeld;
    logic clearSet;
  } ctlStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_FILL, ST_REPLAY, ST_INVAL
  } cacheState_t;
endpackage

// File: rtl/vipt_cache_ctl.sv
module vipt_cache_ctl
  import vipt_pkg::*;
#(
  parameter int SETS = 128
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    invAll,
  input  logic                    reqValid,
  input  logic                    ppnValid,
  input  logic                    fillValid,
  input  logic                    hit,
  input  logic                    lastBeat,
  input  logic                    heldWrite,
  output logic                    reqReady,
  output logic                    rspValid,
  output logic                    memReqValid,
  output ctlStrobes_t             ctl,
  output logic [$clog2(SETS)-1:0] clearIdx
);
  localparam int SET_W = $clog2(SETS);

  cacheState_t state, nxt;

  always_comb begin
    ctl         = '0;
    nxt         = state;
    reqReady    = 1'b0;
    rspValid    = 1'b0;
    memReqValid = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady = !invAll;
        if (invAll) nxt = ST_INVAL;
        else if (reqValid) begin
          ctl.latchReq = 1'b1;
          nxt = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (ppnValid) begin
          nxt = ST_IDLE;
          if (heldWrite) begin
            rspValid      = 1'b1;
            memReqValid   = 1'b1;
            ctl.storeWord = hit;
            ctl.touch     = hit;
          end else if (hit) begin
            rspValid  = 1'b1;
            ctl.touch = 1'b1;
          end else begin
            memReqValid   = 1'b1;
            ctl.startFill = 1'b1;
            nxt = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        if (fillValid) begin
          ctl.writeBeat = 1'b1;
          if (lastBeat) begin
            ctl.finishFill = 1'b1;
            nxt = ST_REPLAY;
          end
        end
      end
      ST_REPLAY: begin
        ctl.useHeld = 1'b1;
        ctl.touch   = 1'b1;
        rspValid    = 1'b1;
        nxt = ST_IDLE;
      end
      ST_INVAL: begin
        ctl.clearSet = 1'b1;
        if (clearIdx == SET_W'(SETS - 1)) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      clearIdx <= '0;
    end else begin
      state <= nxt;
      if (state == ST_INVAL) clearIdx <= clearIdx + 1'b1;
      else clearIdx <= '0;
    end
  end
endmodule

// File: rtl/vipt_cache_dp.sv
module vipt_cache_dp
  import vipt_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_W     = 12,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int SETS       = 128
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobes_t                ctl,
  input  logic [$clog2(SETS)-1:0]    clearIdx,
  input  logic                       reqWrite,
  input  logic [PAGE_W-1:0]          reqOffs,
  input  logic [DATA_W-1:0]          reqWdata,
  input  logic [ADDR_W-PAGE_W-1:0]   ppn,
  input  logic [DATA_W-1:0]          fillData,
  output logic                       hit,
  output logic                       lastBeat,
  output logic                       heldWrite,
  output logic [DATA_W-1:0]          rspData,
  output logic [ADDR_W-1:0]          memReqAddr,
  output logic [DATA_W-1:0]          memReqWdata
);
  localparam int WAYS   = 4;
  localparam int WAY_W  = 2;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - PAGE_W;
  localparam int WB_W   = $clog2(DATA_W / 8);
  localparam int BEATS  = LINE_BYTES / (DATA_W / 8);
  localparam int BEAT_W = $clog2(BEATS);
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int LINES  = SETS * WAYS;

  logic [SET_W-1:0]  curSet;
  logic [OFF_W-1:0]  curOff;
  logic [DATA_W-1:0] curWdata;
  logic [TAG_W-1:0]  heldTag;
  logic [WAY_W-1:0]  fillWay, hitWay, victim;
  logic [BEAT_W-1:0] beatCnt, curWord;
  logic [TAG_W-1:0]  cmpTag;
  logic [WAYS-1:0]   hitVec;
  logic [LINE_W-1:0] hitLine;

  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [LINE_W-1:0] dataArr [LINES];
  logic [LINES-1:0]  validArr;
  logic [2:0]        plru    [SETS];

  function automatic logic [2:0] plruTouch(input logic [2:0] p, input logic [1:0] w);
    logic [2:0] n;
    n    = p;
    n[0] = ~w[1];
    if (!w[1]) n[1] = ~w[0];
    else       n[2] = ~w[0];
    return n;
  endfunction

  assign cmpTag  = ctl.useHeld ? heldTag : ppn;
  assign curWord = curOff[OFF_W-1:WB_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hitVec[w] = validArr[{curSet, WAY_W'(w)}] && (tagArr[{curSet, WAY_W'(w)}] == cmpTag);
  end

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++) if (hitVec[w]) hitWay = WAY_W'(w);
  end

  always_comb begin
    victim = plru[curSet][0] ? {1'b1, plru[curSet][2]} : {1'b0, plru[curSet][1]};
    for (int w = WAYS - 1; w >= 0; w--)
      if (!validArr[{curSet, WAY_W'(w)}]) victim = WAY_W'(w);
  end

  assign hit         = |hitVec;
  assign lastBeat    = (beatCnt == BEAT_W'(BEATS - 1));
  assign hitLine     = dataArr[{curSet, hitWay}];
  assign rspData     = hitLine[curWord * DATA_W +: DATA_W];
  assign memReqAddr  = {ppn, curSet, heldWrite ? curOff : OFF_W'(0)};
  assign memReqWdata = curWdata;

  always_ff @(posedge clk) begin
    if (ctl.latchReq) begin
      curSet    <= reqOffs[PAGE_W-1:OFF_W];
      curOff    <= reqOffs[OFF_W-1:0];
      heldWrite <= reqWrite;
      curWdata  <= reqWdata;
    end
    if (ctl.startFill) begin
      tagArr[{curSet, victim}] <= ppn;
      heldTag <= ppn;
      fillWay <= victim;
      beatCnt <= '0;
    end
    if (ctl.writeBeat) begin
      dataArr[{curSet, fillWay}][beatCnt * DATA_W +: DATA_W] <= fillData;
      beatCnt <= beatCnt + 1'b1;
    end
    if (ctl.storeWord)
      dataArr[{curSet, hitWay}][curWord * DATA_W +: DATA_W] <= curWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validArr <= '0;
      for (int s = 0; s < SETS; s++) plru[s] <= 3'b000;
    end else begin
      if (ctl.startFill)  validArr[{curSet, victim}]  <= 1'b0;
      if (ctl.finishFill) validArr[{curSet, fillWay}] <= 1'b1;
      if (ctl.touch)      plru[curSet] <= plruTouch(plru[curSet], hitWay);
      if (ctl.clearSet) begin
        for (int w = 0; w < WAYS; w++) validArr[{clearIdx, WAY_W'(w)}] <= 1'b0;
        plru[clearIdx] <= 3'b000;
      end
    end
  end
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
  import vipt_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_W     = 12,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int SETS       = 128
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     invAll,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic                     reqWrite,
  input  logic [PAGE_W-1:0]        reqOffs,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic                     ppnValid,
  input  logic [ADDR_W-PAGE_W-1:0] ppn,
  output logic                     rspValid,
  output logic [DATA_W-1:0]        rspData,
  output logic                     memReqValid,
  output logic                     memReqWrite,
  output logic [ADDR_W-1:0]        memReqAddr,
  output logic [DATA_W-1:0]        memReqWdata,
  input  logic                     fillValid,
  input  logic [DATA_W-1:0]        fillData
);
  ctlStrobes_t             ctl;
  logic [$clog2(SETS)-1:0] clearIdx;
  logic                    hit, lastBeat, heldWrite;

  assign memReqWrite = heldWrite;

  vipt_cache_ctl #(.SETS(SETS)) u_ctl (
    .clk(clk), .rstN(rstN), .invAll(invAll), .reqValid(reqValid),
    .ppnValid(ppnValid), .fillValid(fillValid), .hit(hit), .lastBeat(lastBeat),
    .heldWrite(heldWrite), .reqReady(reqReady), .rspValid(rspValid),
    .memReqValid(memReqValid), .ctl(ctl), .clearIdx(clearIdx)
  );

  vipt_cache_dp #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
    .LINE_BYTES(LINE_BYTES), .SETS(SETS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .clearIdx(clearIdx), .reqWrite(reqWrite),
    .reqOffs(reqOffs), .reqWdata(reqWdata), .ppn(ppn), .fillData(fillData),
    .hit(hit), .lastBeat(lastBeat), .heldWrite(heldWrite), .rspData(rspData),
    .memReqAddr(memReqAddr), .memReqWdata(memReqWdata)
  );
endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk #(
  parameter int OFF_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             invAll,
  input logic             reqValid,
  input logic             reqReady,
  input logic             ppnValid,
  input logic             fillValid,
  input logic             rspValid,
  input logic             memReqValid,
  input logic             memReqWrite,
  input logic [OFF_W-1:0] addrLow
);
  AST_RSP_AFTER_PPN: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (ppnValid || $past(fillValid))); // R3
  AST_MISS_NO_RSP: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqWrite) |-> !rspValid); // R5
  AST_FILL_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqWrite) |-> (addrLow == '0)); // R5
  AST_STORE_ACKED: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |-> rspValid); // R8
  AST_ACCEPT_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R2
  AST_INV_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(reqReady && !reqValid) && invAll) |=> !reqReady); // R10
endmodule

bind vipt_cache vipt_cache_chk #(.OFF_W($clog2(LINE_BYTES))) u_chk (
  .clk(clk), .rstN(rstN), .invAll(invAll), .reqValid(reqValid), .reqReady(reqReady),
  .ppnValid(ppnValid), .fillValid(fillValid), .rspValid(rspValid),
  .memReqValid(memReqValid), .memReqWrite(memReqWrite),
  .addrLow(memReqAddr[$clog2(LINE_BYTES)-1:0])
);

// File: tb/vipt_cache_tb.sv
module vipt_cache_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        invAll = 1'b0, reqValid = 1'b0, reqWrite = 1'b0;
  logic [11:0] reqOffs = '0;
  logic [31:0] reqWdata = '0;
  logic        ppnValid = 1'b0;
  logic [19:0] ppn = '0;
  logic        fillValid = 1'b0;
  logic [31:0] fillData = '0;
  logic        reqReady, rspValid, memReqValid, memReqWrite;
  logic [31:0] rspData, memReqAddr, memReqWdata;

  int total = 0;
  int failed = 0;

  always #10 clk = ~clk;

  vipt_cache u_dut (
    .clk(clk), .rstN(rstN), .invAll(invAll), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqOffs(reqOffs), .reqWdata(reqWdata), .ppnValid(ppnValid),
    .ppn(ppn), .rspValid(rspValid), .rspData(rspData), .memReqValid(memReqValid),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr), .memReqWdata(memReqWdata),
    .fillValid(fillValid), .fillData(fillData)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] fillWord(input logic [19:0] p, input logic [6:0] idx,
                                           input logic [2:0] beat);
    return {p[11:0], 1'b0, idx, beat, 9'h15A};
  endfunction

  // Read; on a miss, supply the line and check the replayed word (R4, R5, R6)
  task automatic doRead(input logic [19:0] p, input logic [6:0] idx, input logic [2:0] word,
                        input int delay, input bit expHit, input logic [31:0] expData);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqOffs = {idx, word, 2'b00};
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R2", "ready after accept", {31'd0, reqReady}, 32'd0);
    for (int d = 0; d < delay; d++) begin
      check(!rspValid && !memReqValid, "R3", "output before ppn",
            {30'd0, rspValid, memReqValid}, 32'd0);
      @(negedge clk);
    end
    ppnValid = 1'b1; ppn = p;
    #1;
    if (expHit) begin
      check(rspValid && !memReqValid, "R4", "hit strobes", {30'd0, rspValid, memReqValid}, 32'd2);
      check(rspData == expData, "R4", "hit data", rspData, expData);
    end else begin
      check(memReqValid && !memReqWrite && !rspValid, "R5", "miss strobes",
            {29'd0, memReqValid, memReqWrite, rspValid}, 32'd4);
      check(memReqAddr == {p, idx, 5'b0}, "R5", "fill address", memReqAddr, {p, idx, 5'b0});
    end
    @(negedge clk);
    ppnValid = 1'b0;
    if (!expHit) begin
      for (int b = 0; b < 8; b++) begin
        fillValid = 1'b1; fillData = fillWord(p, idx, 3'(b));
        @(negedge clk);
      end
      fillValid = 1'b0;
      #1;
      check(rspValid == 1'b1, "R6", "replay valid", {31'd0, rspValid}, 32'd1);
      check(rspData == expData, "R6", "replay data", rspData, expData);
      @(negedge clk);
    end
  endtask

  task automatic doStore(input logic [19:0] p, input logic [6:0] idx, input logic [2:0] word,
                         input logic [31:0] wd);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqOffs = {idx, word, 2'b00}; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0; ppnValid = 1'b1; ppn = p;
    #1;
    check(memReqValid && memReqWrite && rspValid, "R8", "store strobes",
          {29'd0, memReqValid, memReqWrite, rspValid}, 32'd7);
    check(memReqAddr == {p, idx, word, 2'b00}, "R8", "store address", memReqAddr,
          {p, idx, word, 2'b00});
    check(memReqWdata == wd, "R8", "store data", memReqWdata, wd);
    @(negedge clk);
    ppnValid = 1'b0;
  endtask

  task automatic testReset();
    check(reqReady == 1'b1, "R1", "ready after reset", {31'd0, reqReady}, 32'd1);
    check(!rspValid && !memReqValid, "R1", "idle outputs", {30'd0, rspValid, memReqValid}, 32'd0);
  endtask

  task automatic testMissThenHit();
    doRead(20'h12345, 7'd3, 3'd5, 1, 1'b0, fillWord(20'h12345, 7'd3, 3'd5));  // R1 first access misses
    doRead(20'h12345, 7'd3, 3'd0, 3, 1'b1, fillWord(20'h12345, 7'd3, 3'd0));  // R2 R3 slow ppn
    doRead(20'h12345, 7'd3, 3'd7, 0, 1'b1, fillWord(20'h12345, 7'd3, 3'd7));
    doRead(20'h54321, 7'd3, 3'd1, 0, 1'b0, fillWord(20'h54321, 7'd3, 3'd1));  // other tag, same set
  endtask

  task automatic testReplacement();  // R7
    for (int k = 0; k < 4; k++)
      doRead(20'hA0000 + 20'(k), 7'd9, 3'd2, 0, 1'b0, fillWord(20'hA0000 + 20'(k), 7'd9, 3'd2));
    doRead(20'hA0001, 7'd9, 3'd2, 0, 1'b1, fillWord(20'hA0001, 7'd9, 3'd2));
    doRead(20'hA0004, 7'd9, 3'd2, 0, 1'b0, fillWord(20'hA0004, 7'd9, 3'd2));  // evicts way 2
    doRead(20'hA0000, 7'd9, 3'd3, 0, 1'b1, fillWord(20'hA0000, 7'd9, 3'd3));  // R7 survivor
    doRead(20'hA0003, 7'd9, 3'd3, 0, 1'b1, fillWord(20'hA0003, 7'd9, 3'd3));  // R7 survivor
    doRead(20'hA0001, 7'd9, 3'd3, 0, 1'b1, fillWord(20'hA0001, 7'd9, 3'd3));  // R7 survivor
    doRead(20'hA0002, 7'd9, 3'd3, 0, 1'b0, fillWord(20'hA0002, 7'd9, 3'd3));  // R7 victim gone
  endtask

  task automatic testStores();
    doStore(20'h12345, 7'd3, 3'd2, 32'hDEADBEEF);  // R8 hit updates line
    doRead(20'h12345, 7'd3, 3'd2, 0, 1'b1, 32'hDEADBEEF);
    doStore(20'h55555, 7'd4, 3'd1, 32'h0BADF00D);  // R9 miss, no allocation
    doRead(20'h55555, 7'd4, 3'd1, 0, 1'b0, fillWord(20'h55555, 7'd4, 3'd1));
  endtask

  task automatic testInvalidate();  // R10
    int lowCnt;
    @(negedge clk);
    invAll = 1'b1;
    #1;
    check(reqReady == 1'b0, "R10", "ready in invalidate cycle", {31'd0, reqReady}, 32'd0);
    @(negedge clk);
    invAll = 1'b0;
    lowCnt = 0;
    while (!reqReady && lowCnt < 300) begin
      lowCnt++;
      @(negedge clk);
    end
    check(lowCnt == 128, "R10", "stall cycles", 32'(lowCnt), 32'd128);
    doRead(20'h12345, 7'd3, 3'd2, 0, 1'b0, fillWord(20'h12345, 7'd3, 3'd2));
    doRead(20'hA0003, 7'd9, 3'd0, 0, 1'b0, fillWord(20'hA0003, 7'd9, 3'd0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testMissThenHit();
    testReplacement();
    testStores();
    testInvalidate();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog: actual %0d cycles expected completion", 200000);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule